// File: doc/BRIEF.md
# In-Place Bit-Reversal Sorter

This block reorders a power-of-two sample set held in a pair of word arrays, one for real parts and one for imaginary parts. After the sort, each location holds the word that was at the location whose index is the bit-mirror of its own. This prepares data for a radix-2 transform that wants its input, or gives its output, in mirrored order. The arrays sit inside the block as a single-port store with one shared address. While the block is idle, a host port writes and reads both arrays.

A one-cycle start pulse begins a pass. The controller visits every index in ascending order. It exchanges a pair only when the mirrored index is larger than the current one, so indices that map to themselves are skipped and no pair is handled twice. Each exchange is two reads followed by two writes. A half-size table supplies the mirrored index of every lower-half index. For an upper-half index, the mirror is the table entry for (index − N/2) plus one. A mode input, captured at start, chooses between sorting the real array alone and sorting both arrays.

Top module: `brev_sorter`

## Requirements
- R1: After a pass, real location i holds the word that was at location rev(i), for every i. Here rev(i) is i with its LOG2N bits in mirrored order, and N = 2^LOG2N with LOG2N from 2 to 10.
- R2: Locations whose index equals its own mirror keep their contents across a pass.
- R3: Each mirrored pair is exchanged exactly once per pass, so one pass applies the permutation once and a second pass restores the original order.
- R4: Upper-half indices (MSB of the index = 1) land on the correct partner, i.e. table entry of (i − N/2) plus one.
- R5: With `both_arrays`=1 at start, the imaginary array is permuted like the real one. With `both_arrays`=0, every imaginary word is left unchanged.
- R6: `done` is high for exactly one cycle at the end of a pass. `busy` is high from the cycle after start until `done`, and is low while `done` is high.
- R7: A start pulse that arrives while `busy` is high is ignored: the pass is neither restarted nor extended.
- R8: After reset, `busy` and `done` are low.
- R9: A pass takes N + 4·S + 1 clock edges from the edge that samples start to the first edge after which `done` is high, where S is the number of indices i with rev(i) > i.
- R10: Host writes issued while `busy` is high have no effect on either array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a pass when idle |
| both_arrays | input | 1 | 1: sort real and imaginary arrays; 0: real array only |
| host_we | input | 1 | Host write strobe for both arrays (idle only) |
| host_addr | input | LOG2N | Host read/write index |
| host_wr_re | input | DW | Host write data, real array |
| host_wr_im | input | DW | Host write data, imaginary array |
| host_rd_re | output | DW | Real word at host_addr |
| host_rd_im | output | DW | Imaginary word at host_addr |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass flag |

## Verification
Arrays are filled with distinct values derived from the index and a pattern seed, so any misplaced word differs from its expected value. A pass in both-array mode shows whether the real and imaginary arrays are both permuted. A real-only pass shows whether the imaginary array is left alone. A second pass over already-sorted data separates a single exchange per pair from a double one, because the data must return to its original order. A run disturbed by an extra start pulse and a stray host write, with its edge count compared against N + 4·S + 1, separates an ignored request from one that restarts or corrupts the pass.

// File: rtl/brev_pkg.sv
package brev_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_RDA,
    ST_RDB,
    ST_WRA,
    ST_WRB,
    ST_DONE
  } brev_state_e;
endpackage

// File: rtl/brev_lut.sv
module brev_lut #(
  parameter int LOG2N = 4
) (
  input  logic [LOG2N-1:0] idx,
  output logic [LOG2N-1:0] rev
);
  localparam int HALF = (1 << LOG2N) / 2;

  function automatic logic [LOG2N-1:0] mirror(input logic [LOG2N-1:0] v);
    logic [LOG2N-1:0] r;
    for (int b = 0; b < LOG2N; b++) r[b] = v[LOG2N-1-b];
    return r;
  endfunction

  logic [LOG2N-1:0] tbl [HALF];

  for (genvar g = 0; g < HALF; g++) begin : g_tbl
    assign tbl[g] = mirror(LOG2N'(g));
  end

  logic [LOG2N-1:0] base;
  assign base = tbl[idx[LOG2N-2:0]];
  assign rev  = idx[LOG2N-1] ? base + LOG2N'(1) : base;
endmodule

// File: rtl/brev_mem.sv
module brev_mem #(
  parameter int LOG2N = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             re_we,
  input  logic             im_we,
  input  logic [LOG2N-1:0] addr,
  input  logic [DW-1:0]    wr_re,
  input  logic [DW-1:0]    wr_im,
  output logic [DW-1:0]    rd_re,
  output logic [DW-1:0]    rd_im
);
  localparam int DEPTH = 1 << LOG2N;

  logic [DW-1:0] re_arr [DEPTH];
  logic [DW-1:0] im_arr [DEPTH];

  always_ff @(posedge clk) begin
    if (re_we) re_arr[addr] <= wr_re;
  end

  always_ff @(posedge clk) begin
    if (im_we) im_arr[addr] <= wr_im;
  end

  assign rd_re = re_arr[addr];
  assign rd_im = im_arr[addr];
endmodule

// File: rtl/brev_ctrl.sv
module brev_ctrl
  import brev_pkg::*;
#(
  parameter int LOG2N = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             both_in,
  input  logic [LOG2N-1:0] rev,
  output logic [LOG2N-1:0] idx,
  output logic [LOG2N-1:0] m_addr,
  output logic             m_we,
  output logic             m_im_en,
  output logic [DW-1:0]    m_wr_re,
  output logic [DW-1:0]    m_wr_im,
  input  logic [DW-1:0]    m_rd_re,
  input  logic [DW-1:0]    m_rd_im,
  output logic             busy,
  output logic             done
);
  localparam logic [LOG2N-1:0] LAST = {LOG2N{1'b1}};

  brev_state_e      state_q, state_d;
  logic [LOG2N-1:0] idx_q, idx_d;
  logic             both_q, both_d;
  logic [DW-1:0]    a_re_q, a_im_q, b_re_q, b_im_q;
  logic             ld_a, ld_b;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    both_d  = both_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SCAN;
          idx_d   = '0;
          both_d  = both_in;
        end
      end
      ST_SCAN: begin
        if (rev > idx_q)        state_d = ST_RDA;
        else if (idx_q == LAST) state_d = ST_DONE;
        else                    idx_d   = idx_q + LOG2N'(1);
      end
      ST_RDA: state_d = ST_RDB;
      ST_RDB: state_d = ST_WRA;
      ST_WRA: state_d = ST_WRB;
      ST_WRB: begin
        if (idx_q == LAST) state_d = ST_DONE;
        else begin
          state_d = ST_SCAN;
          idx_d   = idx_q + LOG2N'(1);
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      both_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      both_q  <= both_d;
    end
  end

  assign ld_a = (state_q == ST_RDA);
  assign ld_b = (state_q == ST_RDB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_re_q <= '0;
      a_im_q <= '0;
    end else if (ld_a) begin
      a_re_q <= m_rd_re;
      a_im_q <= m_rd_im;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_re_q <= '0;
      b_im_q <= '0;
    end else if (ld_b) begin
      b_re_q <= m_rd_re;
      b_im_q <= m_rd_im;
    end
  end

  always_comb begin
    m_addr  = idx_q;
    m_we    = 1'b0;
    m_wr_re = b_re_q;
    m_wr_im = b_im_q;
    case (state_q)
      ST_RDB: m_addr = rev;
      ST_WRA: m_we = 1'b1;
      ST_WRB: begin
        m_addr  = rev;
        m_we    = 1'b1;
        m_wr_re = a_re_q;
        m_wr_im = a_im_q;
      end
      default: ;
    endcase
  end

  assign idx     = idx_q;
  assign m_im_en = both_q;
  assign busy    = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done    = (state_q == ST_DONE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_SWAP_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RDA) |-> (rev > idx_q)); // R3

  AST_IDX_HELD_IN_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RDB || state_q == ST_WRA || state_q == ST_WRB) |-> $stable(idx_q)); // R3

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(both_q)); // R5

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R7

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_we); // R10
endmodule

// File: rtl/brev_sorter.sv
module brev_sorter #(
  parameter int LOG2N = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             both_arrays,
  input  logic             host_we,
  input  logic [LOG2N-1:0] host_addr,
  input  logic [DW-1:0]    host_wr_re,
  input  logic [DW-1:0]    host_wr_im,
  output logic [DW-1:0]    host_rd_re,
  output logic [DW-1:0]    host_rd_im,
  output logic             busy,
  output logic             done
);
  logic [LOG2N-1:0] idx, rev, c_addr, m_addr;
  logic             c_we, c_im_en, re_we, im_we;
  logic [DW-1:0]    c_wr_re, c_wr_im, m_wr_re, m_wr_im, m_rd_re, m_rd_im;

  brev_lut #(.LOG2N(LOG2N)) u_lut (
    .idx (idx),
    .rev (rev)
  );

  brev_ctrl #(.LOG2N(LOG2N), .DW(DW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .both_in (both_arrays),
    .rev     (rev),
    .idx     (idx),
    .m_addr  (c_addr),
    .m_we    (c_we),
    .m_im_en (c_im_en),
    .m_wr_re (c_wr_re),
    .m_wr_im (c_wr_im),
    .m_rd_re (m_rd_re),
    .m_rd_im (m_rd_im),
    .busy    (busy),
    .done    (done)
  );

  always_comb begin
    if (busy) begin
      m_addr  = c_addr;
      re_we   = c_we;
      im_we   = c_we & c_im_en;
      m_wr_re = c_wr_re;
      m_wr_im = c_wr_im;
    end else begin
      m_addr  = host_addr;
      re_we   = host_we;
      im_we   = host_we;
      m_wr_re = host_wr_re;
      m_wr_im = host_wr_im;
    end
  end

  brev_mem #(.LOG2N(LOG2N), .DW(DW)) u_mem (
    .clk   (clk),
    .re_we (re_we),
    .im_we (im_we),
    .addr  (m_addr),
    .wr_re (m_wr_re),
    .wr_im (m_wr_im),
    .rd_re (m_rd_re),
    .rd_im (m_rd_im)
  );

  assign host_rd_re = m_rd_re;
  assign host_rd_im = m_rd_im;
endmodule

// File: tb/sim_brev_sorter.sv
module sim_brev_sorter;
  localparam int CLK_PER = 10;
  localparam int LOG2N   = 4;
  localparam int DW      = 16;
  localparam int N       = 1 << LOG2N;

  logic             clk = 1'b0;
  logic             rst_n, start, both_arrays, host_we;
  logic [LOG2N-1:0] host_addr;
  logic [DW-1:0]    host_wr_re, host_wr_im, host_rd_re, host_rd_im;
  logic             busy, done;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] m_re [N];
  logic [DW-1:0] m_im [N];

  always #(CLK_PER/2) clk = ~clk;

  brev_sorter #(.LOG2N(LOG2N), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .both_arrays(both_arrays),
    .host_we(host_we), .host_addr(host_addr), .host_wr_re(host_wr_re),
    .host_wr_im(host_wr_im), .host_rd_re(host_rd_re), .host_rd_im(host_rd_im),
    .busy(busy), .done(done)
  );

  function automatic int rv(input int i);
    int r = 0;
    for (int b = 0; b < LOG2N; b++) if (((i >> b) & 1) != 0) r |= 1 << (LOG2N-1-b);
    return r;
  endfunction

  function automatic int swaps();
    int s = 0;
    for (int i = 0; i < N; i++) if (rv(i) > i) s++;
    return s;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input int seed);
    for (int i = 0; i < N; i++) begin
      m_re[i] = DW'(i * 37 + seed * 1000 + 5);
      m_im[i] = DW'(16'hF00F ^ (i * 11) ^ seed);
      host_addr = LOG2N'(i); host_wr_re = m_re[i]; host_wr_im = m_im[i];
      host_we = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    host_we = 1'b0;
  endtask

  // run one pass; disturb=1 adds a start pulse and a host write mid-pass
  task automatic run(input logic both, input logic disturb);
    int cnt = 0;
    logic [DW-1:0] t_re [N];
    logic [DW-1:0] t_im [N];
    both_arrays = both; start = 1'b1;
    do begin
      @(posedge clk); cnt++; @(negedge clk);
      start = 1'b0;
      both_arrays = ~both;
      if (disturb && cnt == 7) begin
        start = 1'b1;
        host_we = 1'b1; host_addr = LOG2N'(1); host_wr_re = 16'hDEAD; host_wr_im = 16'hBEEF;
      end else begin
        host_we = 1'b0;
      end
    end while (!done && cnt < 2000);
    host_we = 1'b0; start = 1'b0;
    chk("R9 pass edge count", DW'(cnt), DW'(N + 4 * swaps() + 1));
    chk("R6 busy low with done", DW'(busy), DW'(0));
    @(negedge clk);
    chk("R6 done one cycle", DW'(done), DW'(0));
    chk("R6 busy low after pass", DW'(busy), DW'(0));
    for (int i = 0; i < N; i++) begin t_re[i] = m_re[rv(i)]; t_im[i] = m_im[rv(i)]; end
    for (int i = 0; i < N; i++) begin m_re[i] = t_re[i]; if (both) m_im[i] = t_im[i]; end
  endtask

  task automatic verify(input logic both);
    string rq;
    for (int i = 0; i < N; i++) begin
      host_addr = LOG2N'(i);
      #1;
      if (rv(i) == i) rq = "R2 self-mapped real";
      else if (i >= N/2) rq = "R4 upper-half real";
      else rq = "R1 real order";
      chk(rq, host_rd_re, m_re[i]);
      chk(both ? "R5 imag permuted" : "R5 imag untouched", host_rd_im, m_im[i]);
    end
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; both_arrays = 1'b0; host_we = 1'b0;
    host_addr = '0; host_wr_re = '0; host_wr_im = '0;
    #(CLK_PER * 3);
    @(negedge clk);
    chk("R8 busy after reset", DW'(busy), DW'(0));
    chk("R8 done after reset", DW'(done), DW'(0));
    rst_n = 1'b1;
    @(negedge clk);

    load(0); run(1'b1, 1'b0); verify(1'b1);     // R1 R2 R4 R5 both arrays
    load(1); run(1'b0, 1'b0); verify(1'b0);     // R5 real only
    run(1'b1, 1'b0); verify(1'b1);              // R3 second pass restores real order
    load(2); run(1'b1, 1'b1); verify(1'b1);     // R7 R10 disturbed pass
    load(3); run(1'b0, 1'b1); verify(1'b0);     // R7 R10 real-only disturbed

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule